// File: doc/BRIEF.md
# CCD Vertical Frame Mode Sequencer

This block keeps the vertical line position of an interline CCD readout and decides which accumulation mode the sensor runs in. In monitoring (field accumulation) mode it runs a 525-line vertical period. That period holds two fields, so a vertical sync is raised at two lines of each period. In still-capture (frame accumulation) mode every field lasts 656 lines. The fields alternate between one that reads the odd sensor lines and one that reads the even sensor lines. Each of these fields ends with a charge-sweep burst, and the burst starts at a different line in each of the two fields.

A line strobe from the horizontal timing advances the block by one line. A level mode request chooses the mode, but the block takes it up only at a vertical period boundary. In frame mode that boundary is the end of the even field. The block drops its valid flag for the whole field that follows a change of mode, and also for the first field after reset. In monitoring mode it requests an overflow-drain shutter pulse once in every field. Pulse shaping at the pixel-clock level belongs to a downstream block.

Top module: `vfs_sequencer`

## Requirements
- R1: After reset the block is on line 1 in monitoring mode: `vsync`=1, `odd_field`=1, `sweep_en`=0, `shutter_req`=0.
- R2: Each cycle with `line_stb`=1 advances the line position by exactly one. All outputs hold their values in cycles without a strobe.
- R3: In monitoring mode the period is FIELD_LINES (525) lines. `vsync` is 1 on lines 1 and FIELD_SYNC2 (263) only, and `odd_field` is 1 on lines 1 to 262 and 0 on lines 263 to 525.
- R4: `shutter_req` is 1 in monitoring mode on lines SHUT_LINE (10) and FIELD_SYNC2+SHUT_LINE-1 (272) only. It is never 1 in frame mode.
- R5: In frame mode every field is FRAME_LINES (656) lines and `vsync` is 1 on line 1 only. The first field after entering frame mode reads odd lines (`odd_field`=1), and the following fields alternate 0, 1, and so on.
- R6: `sweep_en` is 1 from line SWEEP_ODD_FIRST (621) through 656 in the odd frame field, and from SWEEP_EVEN_FIRST (645) through 656 in the even frame field. It is never 1 in monitoring mode.
- R7: `mode_req` (1 = frame, 0 = monitoring) is sampled only at the strobe that ends a period. In monitoring mode that is the strobe on line 525. In frame mode it is the strobe on line 656 of the even field. At every other time the request has no effect.
- R8: After a change of mode in either direction, `frame_valid` is 0 for the whole first field of the new mode and returns to 1 at the next field start. A period boundary with no change leaves it at 1.
- R9: `frame_valid` is 0 from reset until the first field start, which is line 263.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_stb | input | 1 | One-cycle pulse per horizontal line |
| mode_req | input | 1 | Requested mode: 1 frame accumulation, 0 monitoring |
| vsync | output | 1 | High for the whole first line of each field |
| sweep_en | output | 1 | Charge-sweep burst window |
| shutter_req | output | 1 | Overflow-drain shutter request line |
| odd_field | output | 1 | Field parity: 1 for first/odd field |
| frame_valid | output | 1 | Readout of the current field is usable |

## Verification
The hardest case to reach from the ports is a mode request that changes exactly when the odd frame field ends. The block must not act on it, because that boundary lies inside a frame. It must stay in frame mode for the even field and switch only when the even field ends. The stimulus walks the strobe through whole periods with a line counter kept in the bench. It drops the request while the odd field's sweep is running and holds it low across the odd-field boundary. It then checks that the even-field sweep starts at line 645 and that the valid flag stays high. A second case raises the request and lowers it again within one monitoring period, and expects no mode change and no loss of valid.

// File: rtl/vfs_pkg.sv
package vfs_pkg;

  typedef enum logic {ACC_FIELD = 1'b0, ACC_FRAME = 1'b1} acc_mode_e;
  typedef enum logic {PH_ODD = 1'b0, PH_EVEN = 1'b1} frame_phase_e;

  // length of the running vertical period, in lines
  function automatic int unsigned period_lines(acc_mode_e m, int unsigned fld_len,
                                               int unsigned frm_len);
    return (m == ACC_FRAME) ? frm_len : fld_len;
  endfunction

  // first line of the charge-sweep window for a frame field
  function automatic int unsigned sweep_first(frame_phase_e p, int unsigned odd_start,
                                              int unsigned even_start);
    return (p == PH_ODD) ? odd_start : even_start;
  endfunction

  // shutter line inside the second monitoring field
  function automatic int unsigned second_shutter(int unsigned sync2, int unsigned ofs);
    return sync2 + ofs - 1;
  endfunction

endpackage

// File: rtl/vfs_line_ctr.sv
module vfs_line_ctr
  import vfs_pkg::*;
#(
  parameter int unsigned CW          = 10,
  parameter int unsigned FIELD_LINES = 525,
  parameter int unsigned FRAME_LINES = 656
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_stb,
  input  acc_mode_e     mode,
  output logic [CW-1:0] line_no,
  output logic          wrap_evt
);
  localparam logic [CW-1:0] FIRST = CW'(1);

  logic [CW-1:0] last_line;
  assign last_line = CW'(period_lines(mode, FIELD_LINES, FRAME_LINES));
  assign wrap_evt  = line_stb && (line_no == last_line);

  always_ff @(posedge clk) begin
    if (!rst_n)        line_no <= FIRST;
    else if (line_stb) line_no <= wrap_evt ? FIRST : line_no + FIRST;
  end
endmodule

// File: rtl/vfs_mode_ctrl.sv
module vfs_mode_ctrl
  import vfs_pkg::*;
#(
  parameter int unsigned CW          = 10,
  parameter int unsigned FIELD_SYNC2 = 263
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_stb,
  input  logic          mode_req,
  input  logic [CW-1:0] line_no,
  input  logic          wrap_evt,
  output acc_mode_e     mode_q,
  output frame_phase_e  phase_q,
  output logic          valid_q,
  output logic          accept_evt,
  output logic          mid_evt
);
  localparam logic [CW-1:0] MID_LAST = CW'(FIELD_SYNC2 - 1);

  acc_mode_e req_mode;
  assign req_mode = mode_req ? ACC_FRAME : ACC_FIELD;

  // boundary inside a frame: odd field ends, mode is kept
  logic half_frame_evt;
  assign half_frame_evt = wrap_evt && (mode_q == ACC_FRAME) && (phase_q == PH_ODD);
  assign accept_evt     = wrap_evt && !half_frame_evt;
  assign mid_evt        = line_stb && (mode_q == ACC_FIELD) && (line_no == MID_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= ACC_FIELD;
      phase_q <= PH_ODD;
      valid_q <= 1'b0;
    end else if (half_frame_evt) begin
      phase_q <= PH_EVEN;
      valid_q <= 1'b1;
    end else if (accept_evt) begin
      mode_q  <= req_mode;
      phase_q <= PH_ODD;
      valid_q <= (req_mode == mode_q);
    end else if (mid_evt) begin
      valid_q <= 1'b1;
    end
  end
endmodule

// File: rtl/vfs_out_decode.sv
module vfs_out_decode
  import vfs_pkg::*;
#(
  parameter int unsigned CW               = 10,
  parameter int unsigned FIELD_SYNC2      = 263,
  parameter int unsigned SWEEP_ODD_FIRST  = 621,
  parameter int unsigned SWEEP_EVEN_FIRST = 645,
  parameter int unsigned SHUT_LINE        = 10
) (
  input  acc_mode_e     mode,
  input  frame_phase_e  phase,
  input  logic [CW-1:0] line_no,
  output logic          vsync,
  output logic          sweep_en,
  output logic          shutter_req,
  output logic          odd_field
);
  localparam logic [CW-1:0] FIRST  = CW'(1);
  localparam logic [CW-1:0] SYNC2  = CW'(FIELD_SYNC2);
  localparam logic [CW-1:0] SHUT_A = CW'(SHUT_LINE);
  localparam logic [CW-1:0] SHUT_B = CW'(second_shutter(FIELD_SYNC2, SHUT_LINE));

  logic          in_field;
  logic [CW-1:0] sweep_start;
  assign in_field    = (mode == ACC_FIELD);
  assign sweep_start = CW'(sweep_first(phase, SWEEP_ODD_FIRST, SWEEP_EVEN_FIRST));

  always_comb begin
    vsync       = (line_no == FIRST) || (in_field && line_no == SYNC2);
    odd_field   = in_field ? (line_no < SYNC2) : (phase == PH_ODD);
    sweep_en    = !in_field && (line_no >= sweep_start);
    shutter_req = in_field && (line_no == SHUT_A || line_no == SHUT_B);
  end
endmodule

// File: rtl/vfs_sequencer.sv
module vfs_sequencer
  import vfs_pkg::*;
#(
  parameter int unsigned FIELD_LINES      = 525,
  parameter int unsigned FIELD_SYNC2      = 263,
  parameter int unsigned FRAME_LINES      = 656,
  parameter int unsigned SWEEP_ODD_FIRST  = 621,
  parameter int unsigned SWEEP_EVEN_FIRST = 645,
  parameter int unsigned SHUT_LINE        = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_stb,
  input  logic mode_req,
  output logic vsync,
  output logic sweep_en,
  output logic shutter_req,
  output logic odd_field,
  output logic frame_valid
);
  localparam int unsigned MAXL = (FRAME_LINES > FIELD_LINES) ? FRAME_LINES : FIELD_LINES;
  localparam int unsigned CW   = $clog2(MAXL + 1);

  logic [CW-1:0] line_no;
  logic          wrap_evt;
  logic          accept_evt;
  logic          mid_evt;
  acc_mode_e     mode_q;
  frame_phase_e  phase_q;
  logic          valid_q;

  vfs_line_ctr #(.CW(CW), .FIELD_LINES(FIELD_LINES), .FRAME_LINES(FRAME_LINES)) u_ctr (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .mode(mode_q),
    .line_no(line_no), .wrap_evt(wrap_evt)
  );

  vfs_mode_ctrl #(.CW(CW), .FIELD_SYNC2(FIELD_SYNC2)) u_mode (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .mode_req(mode_req),
    .line_no(line_no), .wrap_evt(wrap_evt), .mode_q(mode_q), .phase_q(phase_q),
    .valid_q(valid_q), .accept_evt(accept_evt), .mid_evt(mid_evt)
  );

  vfs_out_decode #(
    .CW(CW), .FIELD_SYNC2(FIELD_SYNC2), .SWEEP_ODD_FIRST(SWEEP_ODD_FIRST),
    .SWEEP_EVEN_FIRST(SWEEP_EVEN_FIRST), .SHUT_LINE(SHUT_LINE)
  ) u_dec (
    .mode(mode_q), .phase(phase_q), .line_no(line_no), .vsync(vsync),
    .sweep_en(sweep_en), .shutter_req(shutter_req), .odd_field(odd_field)
  );

  assign frame_valid = valid_q;
endmodule

// File: rtl/vfs_seq_chk.sv
module vfs_seq_chk #(
  parameter int unsigned CW          = 10,
  parameter int unsigned FRAME_LINES = 656
) (
  input logic          clk,
  input logic          rst_n,
  input logic          line_stb,
  input logic          wrap_evt,
  input logic          accept_evt,
  input logic          mid_evt,
  input logic          mode_q,
  input logic [CW-1:0] line_no,
  input logic          vsync,
  input logic          sweep_en,
  input logic          shutter_req,
  input logic          frame_valid
);
  // R2
  line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_no >= CW'(1)) && (line_no <= CW'(FRAME_LINES)));

  // R2
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_stb |=> $stable(line_no) && $stable(vsync) && $stable(frame_valid)
                  && $stable(sweep_en) && $stable(shutter_req));

  // R3
  wrap_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> vsync && (line_no == CW'(1)));

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_evt |=> $stable(mode_q));

  // R8
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_valid) |-> $past(accept_evt));

  // R9
  valid_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mid_evt |=> frame_valid);

  // R4
  shutter_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutter_req |-> !mode_q && !sweep_en);

  // R6
  sweep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_en && !wrap_evt) |=> sweep_en);
endmodule

bind vfs_sequencer vfs_seq_chk #(.CW(CW), .FRAME_LINES(FRAME_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .wrap_evt(wrap_evt),
  .accept_evt(accept_evt), .mid_evt(mid_evt), .mode_q(mode_q), .line_no(line_no),
  .vsync(vsync), .sweep_en(sweep_en), .shutter_req(shutter_req),
  .frame_valid(frame_valid)
);

// File: tb/vfs_sequencer_test.sv
module vfs_sequencer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_stb = 1'b0;
  logic mode_req = 1'b0;
  logic vsync, sweep_en, shutter_req, odd_field, frame_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int cur_line = 1;
  int blen     = 525;

  always #4 clk = ~clk;

  vfs_sequencer uut (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .mode_req(mode_req),
    .vsync(vsync), .sweep_en(sweep_en), .shutter_req(shutter_req),
    .odd_field(odd_field), .frame_valid(frame_valid)
  );

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at line %0d: got %b expected %b", tag, cur_line, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk) line_stb = 1'b1;
    @(negedge clk) line_stb = 1'b0;
    cur_line = (cur_line == blen) ? 1 : cur_line + 1;
  endtask

  task automatic to_line(int target);
    do step(); while (cur_line != target);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 vsync", vsync, 1'b1);
    chk("R1 odd_field", odd_field, 1'b1);
    chk("R1 sweep_en", sweep_en, 1'b0);
    chk("R1 shutter_req", shutter_req, 1'b0);
    chk("R9 valid after reset", frame_valid, 1'b0);
  endtask

  task automatic t_field();
    to_line(10);
    chk("R4 shutter line 10", shutter_req, 1'b1);
    chk("R3 no vsync line 10", vsync, 1'b0);
    repeat (6) @(negedge clk);
    chk("R2 hold without strobe", shutter_req, 1'b1);
    to_line(11);
    chk("R2 one line per strobe", shutter_req, 1'b0);
    to_line(262);
    chk("R3 odd_field line 262", odd_field, 1'b1);
    chk("R9 still invalid line 262", frame_valid, 1'b0);
    to_line(263);
    chk("R3 vsync line 263", vsync, 1'b1);
    chk("R3 even half line 263", odd_field, 1'b0);
    chk("R9 valid at line 263", frame_valid, 1'b1);
    to_line(272);
    chk("R4 shutter line 272", shutter_req, 1'b1);
    to_line(300);
    mode_req = 1'b1;
    to_line(400);
    mode_req = 1'b0;
    to_line(525);
    chk("R3 no vsync line 525", vsync, 1'b0);
    chk("R6 no sweep in field mode", sweep_en, 1'b0);
    to_line(1);
    chk("R3 vsync at wrap", vsync, 1'b1);
    chk("R7 mid-period request ignored, valid", frame_valid, 1'b1);
    to_line(10);
    chk("R7 still field mode, shutter", shutter_req, 1'b1);
  endtask

  task automatic t_to_frame();
    mode_req = 1'b1;
    to_line(525);
    to_line(1);
    blen = 656;
    chk("R8 invalid after entering frame", frame_valid, 1'b0);
    chk("R5 vsync line 1", vsync, 1'b1);
    chk("R5 odd field first", odd_field, 1'b1);
    to_line(10);
    chk("R4 no shutter in frame", shutter_req, 1'b0);
    to_line(263);
    chk("R5 no vsync line 263", vsync, 1'b0);
    chk("R8 invalid whole field", frame_valid, 1'b0);
    to_line(620);
    chk("R6 no sweep line 620", sweep_en, 1'b0);
    to_line(621);
    chk("R6 sweep line 621", sweep_en, 1'b1);
    mode_req = 1'b0;
    to_line(656);
    chk("R6 sweep line 656", sweep_en, 1'b1);
    to_line(1);
    chk("R5 even field", odd_field, 1'b0);
    chk("R7 no switch inside frame, valid", frame_valid, 1'b1);
    chk("R6 sweep ends at wrap", sweep_en, 1'b0);
    to_line(644);
    chk("R6 no sweep line 644", sweep_en, 1'b0);
    to_line(645);
    chk("R7 still frame, sweep line 645", sweep_en, 1'b1);
    to_line(656);
  endtask

  task automatic t_to_field();
    to_line(1);
    blen = 525;
    chk("R8 invalid after leaving frame", frame_valid, 1'b0);
    chk("R3 odd half after return", odd_field, 1'b1);
    chk("R6 no sweep after return", sweep_en, 1'b0);
    to_line(10);
    chk("R4 shutter after return", shutter_req, 1'b1);
    to_line(263);
    chk("R8 valid at next field", frame_valid, 1'b1);
    chk("R3 vsync line 263 after return", vsync, 1'b1);
    to_line(525);
    to_line(1);
    chk("R8 valid kept without change", frame_valid, 1'b1);
  endtask

  initial begin
    t_reset();
    t_field();
    t_to_frame();
    t_to_field();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule